// File: doc/BRIEF.md
# Back-to-back pipelined burst SRAM

This block is a cycle-accurate, synthesizable model of a synchronous pipelined static RAM. Reads and writes may be issued on every enabled clock edge in any mix, with no idle cycle when the bus turns around. Write data follows its address by two enabled edges. Read data is placed in an output register one enabled edge after the address, so the controller samples it at the second edge. Read data and write data therefore share the same bus slot, and the direction of the bus never needs a gap.

An access starts when the load/continue control is low and all three chip selects are in their active states. The access is a read or a write depending on the write strobe. Holding the load/continue control high continues the current access as a burst of up to four words. The burst steps through the low two address bits in either wrapping-increment order or XOR order. Each word holds a parameterized number of 9-bit byte lanes, each of 8 data bits and 1 parity bit, and every lane has its own write select. A clock enable freezes the whole pipeline.

A read issued one cycle after a write to the same word receives the bytes of that write, even though they arrive at the same edge that the read is served. The output-enable pin only gates the drivers, and it does so without a clock.

Top module: `b2b_burst_sram`

## Requirements
- R1: For a read accepted at enabled edge k, the word appears on `dout` after enabled edge k+1, with `dout_oe` high while `drv_en_n` is low. It stays there until the next enabled edge.
- R2: For a write accepted at enabled edge k, `din` is sampled at enabled edge k+2. Byte lane i is bits [9i+8:9i]. It is written only when `lane_wr_n[i]` was low in the cycle of the write, and the lane bits are taken from that cycle, including burst cycles.
- R3: Reads and writes may alternate on every edge. A read of word A accepted one edge after a write to A returns the new bytes of that write merged with the old contents of the other lanes.
- R4: While `clk_en` is low, an edge has no effect: `dout`, `dout_oe`, the burst position and pending writes hold, and `din` is not sampled.
- R5: A load cycle (`burst_cont`=0) is a deselect unless `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0. A deselect writes nothing and produces no read slot. Continue cycles after a deselect are no-ops as well.
- R6: With `burst_cont`=1 and `order_xor`=0, the n-th continued word (n=1..3, wrapping) uses low address bits (start+n) mod 4. The upper address bits and the access kind are kept from the load cycle.
- R7: With `order_xor`=1, the n-th continued word uses low address bits start XOR n.
- R8: A write cycle with every bit of `lane_wr_n` high leaves the addressed word unchanged.
- R9: In the slot where write data is on the bus, `dout_oe` is low whatever `drv_en_n` is. `drv_en_n` high forces `dout_oe` low at once and has no effect on the data that later reads return.
- R10: After `rst_n` is low, no access is pending, no burst is active and `dout_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous clear of pipeline and burst state |
| clk_en | input | 1 | High to act on the edge, low to stall |
| ce_a_n | input | 1 | Chip select, active low |
| ce_b | input | 1 | Chip select, active high |
| ce_c_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Low selects a write on a load cycle |
| burst_cont | input | 1 | Low loads a new address, high continues the burst |
| order_xor | input | 1 | Burst order: 0 wrapping increment, 1 XOR |
| lane_wr_n | input | NB | Per-lane write select, active low |
| addr | input | AW | Word address |
| din | input | NB*9 | Write data bus |
| drv_en_n | input | 1 | Asynchronous output-driver enable, active low |
| dout | output | NB*9 | Registered read data |
| dout_oe | output | 1 | Output driver enable |

## Verification
The assertions assume that `rst_n` is held low for at least one edge before traffic starts. They also assume that `din`, the chip selects and the control pins carry known values at every edge where they are sampled. The forwarding property further relies on `din` being stable through the edge at which a pending write commits. The stimulus changes every input only on falling clock edges and drives every pin with a defined value at all times, including garbage data during stalls and idle slots. It applies reset before any access, so all of these conditions hold throughout.

// File: rtl/sram_pkg.sv
`timescale 1ns/1ps
package sram_pkg;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_RD   = 2'd1,
      OP_WR   = 2'd2
   } op_kind_t;

   // low two address bits of the n-th word of a burst
   function automatic logic [1:0] burst_lsb(input logic [1:0] start,
                                            input logic [1:0] step,
                                            input logic       use_xor);
      logic [1:0] r;
      if (use_xor) r = start ^ step;
      else         r = start + step;
      return r;
   endfunction

endpackage

// File: rtl/sram_burst_ctrl.sv
`timescale 1ns/1ps
module sram_burst_ctrl
   import sram_pkg::*;
#(
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clk_en,
   input  logic          sel,
   input  logic          burst_cont,
   input  logic          wr_req,
   input  logic          order_xor,
   input  logic [AW-1:0] addr,
   output op_kind_t      op_kind,
   output logic [AW-1:0] op_addr
);

   generate
      if (AW < 3) begin : g_bad_aw
         $error("sram_burst_ctrl: AW must be at least 3");
      end
   endgenerate

   logic          act_q;
   op_kind_t      kind_q;
   logic [AW-1:0] base_q;
   logic [1:0]    cnt_q;
   logic [1:0]    cnt_nx;

   assign cnt_nx = cnt_q + 2'd1;

   always_comb begin
      op_kind = OP_NONE;
      op_addr = addr;
      if (!burst_cont) begin
         if (sel) op_kind = wr_req ? OP_WR : OP_RD;
      end else if (act_q) begin
         op_kind = kind_q;
         op_addr = {base_q[AW-1:2], burst_lsb(base_q[1:0], cnt_nx, order_xor)};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         kind_q <= OP_NONE;
         base_q <= '0;
         cnt_q  <= 2'd0;
      end else if (clk_en) begin
         if (!burst_cont) begin
            act_q  <= sel;
            kind_q <= wr_req ? OP_WR : OP_RD;
            base_q <= addr;
            cnt_q  <= 2'd0;
         end else if (act_q) begin
            cnt_q  <= cnt_nx;
         end
      end
   end

   AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && burst_cont && act_q) |=> (cnt_q == $past(cnt_q) + 2'd1)); // R6

   AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && !burst_cont && !sel) |=> (!burst_cont || op_kind == OP_NONE)); // R5

   AST_STALL_CNT: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> ($stable(cnt_q) && $stable(act_q))); // R4

endmodule

// File: rtl/sram_array.sv
`timescale 1ns/1ps
module sram_array #(
   parameter int AW = 6,
   parameter int NB = 4,
   parameter int BW = 9,
   localparam int DW    = NB * BW,
   localparam int DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [NB-1:0] wr_mask,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);

   generate
      if (NB < 1 || BW < 1) begin : g_bad_lane
         $error("sram_array: NB and BW must be positive");
      end
      for (genvar b = 0; b < NB; b++) begin : g_lane
         logic [BW-1:0] cells [DEPTH];
         always_ff @(posedge clk) begin
            if (wr_en && wr_mask[b]) cells[wr_addr] <= wr_data[b*BW +: BW];
         end
         assign rd_data[b*BW +: BW] = cells[rd_addr];
      end
   endgenerate

endmodule

// File: rtl/sram_late_write.sv
`timescale 1ns/1ps
module sram_late_write
   import sram_pkg::*;
#(
   parameter int AW = 6,
   parameter int NB = 4,
   parameter int BW = 9,
   localparam int DW = NB * BW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clk_en,
   input  op_kind_t      op_kind,
   input  logic [AW-1:0] op_addr,
   input  logic [NB-1:0] op_lane_n,
   input  logic [DW-1:0] din,
   input  logic [DW-1:0] mem_rdata,
   output logic [AW-1:0] mem_raddr,
   output logic          commit_we,
   output logic [AW-1:0] commit_addr,
   output logic [NB-1:0] commit_mask,
   output logic [DW-1:0] q_data,
   output logic          q_valid,
   output logic          wr_slot
);

   op_kind_t      s1_kind;
   logic [AW-1:0] s1_addr;
   logic [NB-1:0] s1_mask;
   logic          s2_v;
   logic [AW-1:0] s2_addr;
   logic [NB-1:0] s2_mask;
   logic          hit;
   logic [DW-1:0] fwd_data;

   assign mem_raddr   = s1_addr;
   assign commit_we   = clk_en && s2_v;
   assign commit_addr = s2_addr;
   assign commit_mask = s2_mask;
   assign wr_slot     = s2_v;
   assign hit         = s2_v && (s2_addr == s1_addr);

   generate
      for (genvar b = 0; b < NB; b++) begin : g_fwd
         assign fwd_data[b*BW +: BW] = (hit && s2_mask[b]) ? din[b*BW +: BW]
                                                           : mem_rdata[b*BW +: BW];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_kind <= OP_NONE;
         s1_addr <= '0;
         s1_mask <= '0;
         s2_v    <= 1'b0;
         s2_addr <= '0;
         s2_mask <= '0;
         q_valid <= 1'b0;
         q_data  <= '0;
      end else if (clk_en) begin
         s1_kind <= op_kind;
         s1_addr <= op_addr;
         s1_mask <= ~op_lane_n;
         s2_v    <= (s1_kind == OP_WR);
         s2_addr <= s1_addr;
         s2_mask <= s1_mask;
         q_valid <= (s1_kind == OP_RD);
         if (s1_kind == OP_RD) q_data <= fwd_data;
      end
   end

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> ($stable(q_data) && $stable(q_valid) && $stable(s2_v))); // R4

   AST_SLOT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      s2_v |-> !q_valid); // R9

   AST_FWD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && s1_kind == OP_RD && hit && (&s2_mask)) |=> (q_data == $past(din))); // R3

endmodule

// File: rtl/b2b_burst_sram.sv
`timescale 1ns/1ps
module b2b_burst_sram
   import sram_pkg::*;
#(
   parameter int AW = 6,
   parameter int NB = 4,
   localparam int BW = 9,
   localparam int DW = NB * BW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clk_en,
   input  logic          ce_a_n,
   input  logic          ce_b,
   input  logic          ce_c_n,
   input  logic          wr_n,
   input  logic          burst_cont,
   input  logic          order_xor,
   input  logic [NB-1:0] lane_wr_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] din,
   input  logic          drv_en_n,
   output logic [DW-1:0] dout,
   output logic          dout_oe
);

   logic          sel;
   op_kind_t      op_kind;
   logic [AW-1:0] op_addr;
   logic [AW-1:0] mem_raddr;
   logic [DW-1:0] mem_rdata;
   logic          commit_we;
   logic [AW-1:0] commit_addr;
   logic [NB-1:0] commit_mask;
   logic          q_valid;
   logic          wr_slot;

   assign sel = !ce_a_n && ce_b && !ce_c_n;

   sram_burst_ctrl #(.AW(AW)) u_burst (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sel(sel),
      .burst_cont(burst_cont), .wr_req(!wr_n), .order_xor(order_xor),
      .addr(addr), .op_kind(op_kind), .op_addr(op_addr)
   );

   sram_late_write #(.AW(AW), .NB(NB), .BW(BW)) u_pipe (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .op_kind(op_kind),
      .op_addr(op_addr), .op_lane_n(lane_wr_n), .din(din),
      .mem_rdata(mem_rdata), .mem_raddr(mem_raddr), .commit_we(commit_we),
      .commit_addr(commit_addr), .commit_mask(commit_mask),
      .q_data(dout), .q_valid(q_valid), .wr_slot(wr_slot)
   );

   sram_array #(.AW(AW), .NB(NB), .BW(BW)) u_array (
      .clk(clk), .wr_en(commit_we), .wr_addr(commit_addr),
      .wr_mask(commit_mask), .wr_data(din), .rd_addr(mem_raddr),
      .rd_data(mem_rdata)
   );

   assign dout_oe = q_valid && !drv_en_n;

   AST_WR_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      wr_slot |-> !dout_oe); // R9

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> !dout_oe); // R10

endmodule

// File: tb/sim_b2b_burst_sram.sv
`timescale 1ns/1ps
module sim_b2b_burst_sram;

   localparam int AW    = 6;
   localparam int NB    = 4;
   localparam int BW    = 9;
   localparam int DW    = NB * BW;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clk_en = 1'b1;
   logic          ce_a_n = 1'b1, ce_b = 1'b0, ce_c_n = 1'b1;
   logic          wr_n = 1'b1, burst_cont = 1'b0, order_xor = 1'b0;
   logic [NB-1:0] lane_wr_n = '1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic          drv_en_n = 1'b0;
   logic [DW-1:0] dout;
   logic          dout_oe;

   b2b_burst_sram #(.AW(AW), .NB(NB)) u0 (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .ce_a_n(ce_a_n), .ce_b(ce_b),
      .ce_c_n(ce_c_n), .wr_n(wr_n), .burst_cont(burst_cont),
      .order_xor(order_xor), .lane_wr_n(lane_wr_n), .addr(addr), .din(din),
      .drv_en_n(drv_en_n), .dout(dout), .dout_oe(dout_oe)
   );

   always #10 clk = ~clk;

   int  n_chk = 0, n_fail = 0, nstep = 0;
   bit  done = 1'b0;

   // reference model
   logic [DW-1:0] ref_mem [DEPTH];
   bit            p1_v, p1_w, p2_v;
   logic [AW-1:0] p1_a, p2_a;
   logic [NB-1:0] p1_be, p2_be;
   logic [DW-1:0] p1_d, p2_d;
   bit            b_act, b_w;
   logic [AW-1:0] b_base;
   logic [1:0]    b_cnt;
   bit            e_oe;
   logic [DW-1:0] e_q;

   function automatic logic [DW-1:0] pat(input int n);
      logic [31:0] h;
      h = 32'(n) * 32'h9E3779B1 + 32'h1234567;
      return {h[7:4], h};
   endfunction

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s step %0d: actual %h expected %h", tag, nstep, act, exp);
      end
   endtask

   task automatic step(input bit en, input int selc, input bit cont, input bit wr,
                       input logic [NB-1:0] ben, input logic [AW-1:0] a,
                       input bit ix, input bit oen, input string tag);
      logic [DW-1:0] wd;
      logic [AW-1:0] oa;
      bit ov, ow;
      wd = pat(nstep);
      nstep++;
      @(negedge clk);
      clk_en = en; ce_a_n = (selc == 1); ce_b = (selc != 2); ce_c_n = (selc == 3);
      burst_cont = cont; wr_n = !wr; lane_wr_n = ben; addr = a;
      order_xor = ix; drv_en_n = oen;
      din = (en && p2_v) ? p2_d : ~pat(nstep + 977);
      @(posedge clk);
      if (en) begin
         if (p2_v)
            for (int b = 0; b < NB; b++)
               if (p2_be[b]) ref_mem[p2_a][b*BW +: BW] = p2_d[b*BW +: BW];
         e_oe = p1_v && !p1_w;
         if (e_oe) e_q = ref_mem[p1_a];
         p2_v = p1_v && p1_w; p2_a = p1_a; p2_be = p1_be; p2_d = p1_d;
         ov = 1'b0; ow = 1'b0; oa = a;
         if (!cont) begin
            if (selc == 0) begin
               b_act = 1'b1; b_w = wr; b_base = a; b_cnt = 2'd0; ov = 1'b1; ow = wr;
            end else b_act = 1'b0;
         end else if (b_act) begin
            b_cnt = b_cnt + 2'd1; ov = 1'b1; ow = b_w;
            oa = {b_base[AW-1:2], ix ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt)};
         end
         p1_v = ov; p1_w = ow; p1_a = oa; p1_be = ~ben; p1_d = wd;
      end
      #5;
      chk(tag, DW'(dout_oe), DW'(e_oe && !oen));
      if (e_oe && !oen) chk(tag, dout, e_q);
   endtask

   task automatic idle2();
      step(1, 1, 0, 0, '1, '0, 0, 0, "R5");
      step(1, 0, 1, 0, '1, '0, 0, 0, "R5");
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      p1_v = 0; p2_v = 0; b_act = 0; e_oe = 0; e_q = '0;
      p1_w = 0; p1_a = '0; p1_be = '0; p1_d = '0; p2_a = '0; p2_be = '0; p2_d = '0;
      b_w = 0; b_base = '0; b_cnt = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R10", DW'(dout_oe), '0);
      step(1, 0, 1, 0, '1, '0, 0, 0, "R10");   // continue right after reset: no-op
      step(1, 0, 1, 0, '1, '0, 0, 0, "R10");

      // linear write bursts over every word
      for (int g = 0; g < DEPTH / 4; g++) begin
         step(1, 0, 0, 1, '0, AW'(g * 4 + g % 4), 0, 0, "R2");
         for (int k = 1; k < 4; k++) step(1, 0, 1, 1, '0, '0, 0, 0, "R6");
      end
      idle2();
      // linear read bursts
      for (int g = 0; g < DEPTH / 4; g++) begin
         step(1, 0, 0, 0, '1, AW'(g * 4 + (g + 2) % 4), 0, 0, "R1");
         for (int k = 1; k < 4; k++) step(1, 0, 1, 0, '1, '0, 0, 0, "R6");
      end
      idle2();
      // XOR-order write bursts, then XOR-order read bursts
      for (int g = 0; g < DEPTH / 4; g++) begin
         step(1, 0, 0, 1, '0, AW'(g * 4 + (g + 1) % 4), 1, 0, "R7");
         for (int k = 1; k < 4; k++) step(1, 0, 1, 1, '0, '0, 1, 0, "R7");
      end
      for (int g = 0; g < DEPTH / 4; g++) begin
         step(1, 0, 0, 0, '1, AW'(g * 4 + (g * 3) % 4), 1, 0, "R7");
         for (int k = 1; k < 4; k++) step(1, 0, 1, 0, '1, '0, 1, 0, "R7");
      end
      idle2();
      // alternating write/read, same word and neighbour word
      for (int i = 0; i < DEPTH; i++) begin
         step(1, 0, 0, 1, '0, AW'(i), 0, 0, "R3");
         step(1, 0, 0, 0, '1, AW'(i), 0, 0, "R3");
      end
      for (int i = 0; i < DEPTH; i++) begin
         step(1, 0, 0, 1, NB'(i), AW'(i), 0, 0, "R3");
         step(1, 0, 0, 0, '1, AW'(i ^ 1), 0, 0, "R3");
         step(1, 0, 0, 0, '1, AW'(i), 0, 0, "R3");
      end
      idle2();
      // every lane pattern, including the all-off write abort
      for (int be = 0; be < (1 << NB); be++) begin
         step(1, 0, 0, 1, NB'(be), AW'(5), 0, 0, (be == (1 << NB) - 1) ? "R8" : "R2");
         step(1, 0, 1, 1, NB'(be), '0, 0, 0, (be == (1 << NB) - 1) ? "R8" : "R2");
         step(1, 0, 0, 0, '1, AW'(5), 0, 0, "R8");
         step(1, 0, 1, 0, '1, '0, 0, 0, "R8");
      end
      idle2();
      // stalls mixed into alternating traffic, garbage on din while stalled
      for (int i = 0; i < 96; i++)
         step((i % 3) != 2, 0, (i % 5) == 4, (i % 2) == 0, NB'(i * 7), AW'(i % 8),
              (i % 4) == 1, 0, "R4");
      for (int i = 0; i < 8; i++) step(1, 0, 0, 0, '1, AW'(i), 0, 0, "R4");
      idle2();
      // each chip select failing in turn
      for (int s = 1; s < 4; s++) begin
         step(1, s, 0, 1, '0, AW'(9), 0, 0, "R5");
         step(1, 0, 1, 1, '0, '0, 0, 0, "R5");
         step(1, 0, 1, 0, '1, '0, 0, 0, "R5");
         step(1, 0, 0, 0, '1, AW'(9), 0, 0, "R5");
         step(1, s, 0, 0, '1, AW'(9), 0, 0, "R5");
         step(1, 0, 1, 0, '1, '0, 0, 0, "R5");
      end
      // driver enable toggled against read and write slots
      for (int i = 0; i < 16; i++) begin
         step(1, 0, 0, 0, '1, AW'(i), 0, (i % 3) == 0, "R9");
         step(1, 0, 0, 1, '0, AW'(i + 16), 0, (i % 2) == 0, "R9");
      end
      for (int i = 0; i < 16; i++) step(1, 0, 0, 0, '1, AW'(i + 16), 0, 0, "R9");
      idle2();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule